// File: doc/BRIEF.md
# Redundant-Weight SAR Conversion Sequencer

This block runs one conversion of a 12-bit successive-approximation converter whose capacitor DAC has thirteen non-binary, overlapping weights. After a start pulse it requests thirteen comparator decisions in turn. For each step it drives a DAC control vector that holds the trial bit of the current step above the decisions already taken. It also tells the analog side which comparator answers the step. A fast latch-only comparator answers the first five steps and a preamplified comparator answers the last eight.

Decisions arrive through a valid/ready handshake, so a self-timed comparator sets the pace of each step rather than a fixed number of clock cycles. Each decision goes directly into a running weighted sum. At the last step that sum has a fixed offset removed and is clamped to the 12-bit range to form the output code. The offset cancels the bias that an auxiliary DAC applies. Because the weights overlap, a low decision taken wrongly early in the conversion is recovered by the later steps. The accurate comparator is enabled a step ahead of its first use and is switched off as soon as the conversion ends.

Top module: `sar_redund_ctrl`

## Requirements
- R1: After reset, cmp_ready_o, done_o, fine_en_o, dac_o and result_o are all zero.
- R2: Each accepted start causes exactly 13 decision requests. cmp_ready_o stays high, with dac_o unchanged, until cmp_valid_i is seen, for any number of cycles.
- R3: While step k (0 = first) is requested, dac_o[k] is 1, dac_o[j] for j<k equals the decision accepted at step j, and dac_o[j] for j>k is 0. The default weights of steps 0..12 are 1850, 1000, 560, 310, 170, 96, 52, 28, 16, 8, 4, 2, 1.
- R4: cmp_sel_o is 0 (coarse comparator) for steps 0..4 and 1 (fine comparator) for steps 5..12.
- R5: fine_en_o is high throughout step 4, so it rises at least one cycle before step 5 is requested. It stays high through step 12 and is low whenever no conversion is running.
- R6: One cycle after the last decision is accepted, done_o pulses for exactly one cycle and result_o = clamp(sum of weights whose decision was 1 − OFFSET, 0, 4095). result_o holds its value until the next done.
- R7: With an ideal comparator that returns 1 when x + OFFSET ≥ DAC level, the result equals x for every x in 0..4095.
- R8: A coarse decision returned as 0 where the ideal decision is 1 is corrected by the later steps when the remaining weights cover the residue. For example, x = 2948 with step 1 forced low still gives 2948.
- R9: A start pulse during a conversion is ignored. The running conversion keeps its step and its result.
- R10: A raw sum below OFFSET gives 0, and a raw sum above 4095 + OFFSET gives 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a conversion (ignored while busy) |
| cmp_valid_i | input | 1 | Comparator decision available |
| cmp_dec_i | input | 1 | Comparator decision, 1 = input above DAC level |
| cmp_ready_o | output | 1 | Decision requested for the current step |
| cmp_sel_o | output | 1 | 0 = coarse comparator, 1 = fine comparator |
| fine_en_o | output | 1 | Power enable of the fine comparator |
| dac_o | output | 13 | DAC control bits, bit k = step k |
| result_o | output | 12 | Corrected binary code |
| done_o | output | 1 | One-cycle strobe, result updated |

## Verification
The main instance uses the default weight table and OFFSET = 2. With these values an ideal comparator reaches every code from 0 to 4095 exactly, and a sweep plus forced early errors exercises the redundancy. A second instance is built with OFFSET = 0 and fed all-ones decisions, so its raw sum of 4097 drives the upper clamp; the main instance fed all zeros drives the lower clamp. Comparator latencies of zero to three extra cycles exercise the handshake wait.

// File: rtl/sar_redund_pkg.sv
package sar_redund_pkg;
  localparam int unsigned SAR_NOUT    = 12;
  localparam int unsigned SAR_NSTEP   = 13;
  localparam int unsigned SAR_NCOARSE = 5;
  localparam int unsigned SAR_AW      = SAR_NOUT + 2;

  // index 0 = first decision; each weight <= 1 + sum of later weights
  localparam logic [SAR_NSTEP-1:0][SAR_AW-1:0] SAR_W_DEF = {
    14'd1,   14'd2,   14'd4,   14'd8,   14'd16,  14'd28,  14'd52,
    14'd96,  14'd170, 14'd310, 14'd560, 14'd1000, 14'd1850
  };

  typedef enum logic {ST_IDLE, ST_CONV} sar_st_e;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_redund_pkg::*;
#(
  parameter int unsigned NSTEP   = SAR_NSTEP,
  parameter int unsigned NCOARSE = SAR_NCOARSE,   // must be >= 2
  localparam int unsigned SW     = $clog2(NSTEP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          valid_i,
  output logic          busy_o,
  output logic          start_o,
  output logic          fire_o,
  output logic          last_o,
  output logic [SW-1:0] step_o,
  output logic          sel_o,
  output logic          fine_en_o
);
  sar_st_e       state_q;
  logic [SW-1:0] step_q;
  logic          fine_q;

  assign busy_o    = (state_q == ST_CONV);
  assign start_o   = start_i && (state_q == ST_IDLE);
  assign fire_o    = valid_i && busy_o;
  assign last_o    = fire_o && (step_q == SW'(NSTEP - 1));
  assign step_o    = step_q;
  assign sel_o     = (step_q >= SW'(NCOARSE));
  assign fine_en_o = fine_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      fine_q  <= 1'b0;
    end else begin
      if (start_o) begin
        state_q <= ST_CONV;
        step_q  <= '0;
      end else if (fire_o) begin
        if (last_o) begin
          state_q <= ST_IDLE;
          step_q  <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
      // power up one step ahead of the first fine decision
      if (fire_o && step_q == SW'(NCOARSE - 2)) fine_q <= 1'b1;
      else if (last_o)                          fine_q <= 1'b0;
    end
  end

  a_r5_fine_ahead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && step_q == SW'(NCOARSE)) |-> (fine_q && $past(fine_q)));

  a_r5_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !fine_q);

  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && start_i && !valid_i) |=> (state_q == ST_CONV && $stable(step_q)));
endmodule

// File: rtl/sar_code.sv
module sar_code
  import sar_redund_pkg::*;
#(
  parameter int unsigned NSTEP  = SAR_NSTEP,
  parameter int unsigned NOUT   = SAR_NOUT,
  parameter int unsigned AW     = SAR_AW,
  parameter int unsigned OFFSET = 2,
  parameter logic [NSTEP-1:0][AW-1:0] WEIGHTS = SAR_W_DEF,
  localparam int unsigned SW    = $clog2(NSTEP),
  localparam int unsigned MAXC  = (1 << NOUT) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             start_i,
  input  logic             fire_i,
  input  logic             last_i,
  input  logic [SW-1:0]    step_i,
  input  logic             dec_i,
  output logic [NSTEP-1:0] dac_o,
  output logic [NOUT-1:0]  result_o,
  output logic             done_o
);
  logic [NSTEP-1:0] bits_q;
  logic [AW-1:0]    acc_q, acc_n, sub;
  logic [NOUT-1:0]  res_n, res_q;
  logic             done_q;

  assign dac_o = bits_q | (busy_i ? (NSTEP'(1) << step_i) : '0);

  // decision feeds the sum directly, no capture register in between
  assign acc_n = acc_q + (dec_i ? WEIGHTS[step_i] : '0);
  assign sub   = acc_n - AW'(OFFSET);

  always_comb begin
    if (acc_n < AW'(OFFSET))  res_n = '0;
    else if (sub > AW'(MAXC)) res_n = NOUT'(MAXC);
    else                      res_n = sub[NOUT-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_i;
      if (start_i) begin
        bits_q <= '0;
        acc_q  <= '0;
      end else if (fire_i) begin
        bits_q[step_i] <= dec_i;
        acc_q          <= acc_n;
      end
      if (last_i) res_q <= res_n;
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  a_r3_upper_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> ((bits_q >> step_i) == '0));
endmodule

// File: rtl/sar_redund_ctrl.sv
module sar_redund_ctrl
  import sar_redund_pkg::*;
#(
  parameter int unsigned NOUT    = SAR_NOUT,
  parameter int unsigned NSTEP   = SAR_NSTEP,
  parameter int unsigned NCOARSE = SAR_NCOARSE,
  parameter int unsigned OFFSET  = 2,
  parameter logic [NSTEP-1:0][NOUT+1:0] WEIGHTS = SAR_W_DEF,
  localparam int unsigned AW     = NOUT + 2,
  localparam int unsigned SW     = $clog2(NSTEP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_valid_i,
  input  logic             cmp_dec_i,
  output logic             cmp_ready_o,
  output logic             cmp_sel_o,
  output logic             fine_en_o,
  output logic [NSTEP-1:0] dac_o,
  output logic [NOUT-1:0]  result_o,
  output logic             done_o
);
  logic          busy, start_acc, fire, last;
  logic [SW-1:0] step;

  sar_seq #(.NSTEP(NSTEP), .NCOARSE(NCOARSE)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .valid_i   (cmp_valid_i),
    .busy_o    (busy),
    .start_o   (start_acc),
    .fire_o    (fire),
    .last_o    (last),
    .step_o    (step),
    .sel_o     (cmp_sel_o),
    .fine_en_o (fine_en_o)
  );

  sar_code #(.NSTEP(NSTEP), .NOUT(NOUT), .AW(AW), .OFFSET(OFFSET), .WEIGHTS(WEIGHTS)) u_code (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy),
    .start_i  (start_acc),
    .fire_i   (fire),
    .last_i   (last),
    .step_i   (step),
    .dec_i    (cmp_dec_i),
    .dac_o    (dac_o),
    .result_o (result_o),
    .done_o   (done_o)
  );

  assign cmp_ready_o = busy;

  a_r2_ready_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_ready_o && !cmp_valid_i) |=> (cmp_ready_o && $stable(dac_o)));
endmodule

// File: tb/sar_redund_ctrl_tb_top.sv
module sar_cmp_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ready,
  input  logic [12:0] dac,
  input  logic        sel,
  input  logic        fine_en,
  input  int          x,
  input  int          off,
  input  int          delay,
  input  int          stuck,       // 0 normal, 1 all zero, 2 all one
  input  int          force_step,
  input  int          force_val,
  output logic        valid,
  output logic        dec,
  output int          steps,
  output int          e3,
  output int          e4,
  output int          e5
);
  int bw [13] = '{1850, 1000, 560, 310, 170, 96, 52, 28, 16, 8, 4, 2, 1};
  int k, wait_c, level;
  logic [12:0] hist, expv;
  logic r_prev;

  always @(negedge clk) begin
    if (!rst_n) begin
      valid = 0; dec = 0; steps = 0; e3 = 0; e4 = 0; e5 = 0;
      k = 0; wait_c = 0; hist = '0; r_prev = 0;
    end else begin
      if (valid && r_prev) begin
        hist[k] = dec;
        k = (k == 12) ? 0 : k + 1;
        steps++;
        wait_c = 0;
        valid = 0;
      end
      if (ready) begin
        expv = '0;
        for (int j = 0; j < 13; j++) expv[j] = (j < k) ? hist[j] : (j == k);
        if (dac !== expv) e3++;
        if (sel !== (k >= 5)) e4++;
        if (k >= 4 && !fine_en) e5++;
        if (wait_c >= delay) begin
          level = 0;
          for (int j = 0; j < 13; j++) if (dac[j]) level += bw[j];
          if (stuck == 1)           dec = 0;
          else if (stuck == 2)      dec = 1;
          else if (force_step == k) dec = force_val[0];
          else                      dec = (x + off >= level);
          valid = 1;
        end else wait_c++;
      end else begin
        valid = 0;
        if (fine_en) e5++;
      end
      r_prev = ready;
    end
  end
endmodule

module sar_redund_ctrl_tb_top;
  logic clk = 0, rst_n = 0, start = 0;
  always #5 clk = ~clk;

  int x = 0, delay = 0, stuck = 0, fstep = -1, fval = 0;
  int n_run = 0, n_fail = 0, cyc = 0;

  logic v_a, d_a, r_a, s_a, f_a, done_a;
  logic [12:0] dac_a;
  logic [11:0] res_a;
  int st_a, e3_a, e4_a, e5_a;

  logic v_b, d_b, r_b, s_b, f_b, done_b;
  logic [12:0] dac_b;
  logic [11:0] res_b;
  int st_b, e3_b, e4_b, e5_b;

  sar_redund_ctrl #(.OFFSET(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_valid_i(v_a), .cmp_dec_i(d_a),
    .cmp_ready_o(r_a), .cmp_sel_o(s_a), .fine_en_o(f_a), .dac_o(dac_a),
    .result_o(res_a), .done_o(done_a));

  sar_cmp_model m_a (
    .clk(clk), .rst_n(rst_n), .ready(r_a), .dac(dac_a), .sel(s_a), .fine_en(f_a),
    .x(x), .off(2), .delay(delay), .stuck(stuck), .force_step(fstep), .force_val(fval),
    .valid(v_a), .dec(d_a), .steps(st_a), .e3(e3_a), .e4(e4_a), .e5(e5_a));

  sar_redund_ctrl #(.OFFSET(0)) dut_hi_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmp_valid_i(v_b), .cmp_dec_i(d_b),
    .cmp_ready_o(r_b), .cmp_sel_o(s_b), .fine_en_o(f_b), .dac_o(dac_b),
    .result_o(res_b), .done_o(done_b));

  sar_cmp_model m_b (
    .clk(clk), .rst_n(rst_n), .ready(r_b), .dac(dac_b), .sel(s_b), .fine_en(f_b),
    .x(x), .off(0), .delay(delay), .stuck(2), .force_step(-1), .force_val(0),
    .valid(v_b), .dec(d_b), .steps(st_b), .e3(e3_b), .e4(e4_b), .e5(e5_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // one conversion; restart pulses start mid-conversion (R9)
  task automatic run_conv(input int xv, input int dl, input int fs, input int fv,
                          input int sk, input bit restart, input int exp, input string tag);
    int s0, a3, a4, a5, w;
    x = xv; delay = dl; fstep = fs; fval = fv; stuck = sk;
    s0 = st_a; a3 = e3_a; a4 = e4_a; a5 = e5_a;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    w = 0;
    while (!done_a && w < 400) begin
      @(negedge clk); w++;
      if (restart && w == 8) start = 1;
      else start = 0;
    end
    start = 0;
    chk(done_a === 1'b1, {tag, " R6 done seen"}, done_a, 1);
    chk(res_a === 12'(exp), {tag, " result"}, res_a, exp);
    chk(f_a === 1'b0, {tag, " R5 fine off after end"}, f_a, 0);
    @(negedge clk);
    chk(done_a === 1'b0, {tag, " R6 done one cycle"}, done_a, 0);
    chk(res_a === 12'(exp), {tag, " R6 result held"}, res_a, exp);
    chk(st_a - s0 == 13, {tag, " R2 decision count"}, st_a - s0, 13);
    chk(e3_a == a3, {tag, " R3 dac pattern errors"}, e3_a - a3, 0);
    chk(e4_a == a4, {tag, " R4 comparator select errors"}, e4_a - a4, 0);
    chk(e5_a == a5, {tag, " R5 fine enable errors"}, e5_a - a5, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(r_a === 0, "R1 ready", r_a, 0);
    chk(done_a === 0, "R1 done", done_a, 0);
    chk(f_a === 0, "R1 fine_en", f_a, 0);
    chk(dac_a === '0, "R1 dac", dac_a, 0);
    chk(res_a === '0, "R1 result", res_a, 0);
  endtask

  task automatic t_edges();
    run_conv(0,    0, -1, 0, 0, 0, 0,    "R7 x=0");
    run_conv(1,    1, -1, 0, 0, 0, 1,    "R7 x=1");
    run_conv(2047, 0, -1, 0, 0, 0, 2047, "R7 x=2047");
    run_conv(2048, 2, -1, 0, 0, 0, 2048, "R7 x=2048");
    run_conv(4094, 3, -1, 0, 0, 0, 4094, "R7 x=4094");
    run_conv(4095, 0, -1, 0, 0, 0, 4095, "R7 x=4095");
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 40; i++) begin
      int xv = (i * 1237 + 53) % 4096;
      run_conv(xv, i % 4, -1, 0, 0, 0, xv, "R7 sweep");
    end
  endtask

  task automatic t_correct();
    run_conv(2948, 1, 1, 0, 0, 0, 2948, "R8 step1 low");
    run_conv(1900, 0, 0, 0, 0, 0, 1900, "R8 step0 low");
  endtask

  task automatic t_restart();
    run_conv(3001, 2, -1, 0, 0, 1, 3001, "R9 start while busy");
  endtask

  task automatic t_clamp();
    run_conv(100, 0, -1, 0, 1, 0, 0, "R10 low clamp");
    chk(res_b === 12'd4095, "R10 high clamp", res_b, 4095);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_edges();
    t_sweep();
    t_correct();
    t_restart();
    t_clamp();
    finish_run();
  end
endmodule